// File: doc/BRIEF.md
# Invalidating Snoop Controller with Write-Back Reordering

This block sits on the system side of a caching processor's bus. An external agent hands it a line address and a one-cycle go pulse. The controller then runs a fixed invalidating snoop into the processor. First it raises address hold, so that the processor's address bus turns around and becomes an input. Next it drives the snoop address together with the external address strobe and the invalidate pin. Finally it samples the processor's hit-modified reply.

A modified line forces a write-back. If the processor still has a burst open on the bus at that moment, the controller pulses back-off for one clock. That aborts the burst and clears the bus pipeline, so the write-back becomes the processor's first cycle. The aborted cycle is reissued later. After the write-back burst ends, or straight away when the line was clean or absent, the controller reports done together with a hit flag.

All pin-style controls leave the block from registers, and the active-low ones keep their polarity at the boundary. The controller follows processor bursts itself, from address strobe to the ready beat that carries burst-last.

Top module: `snoop_boff_ctl`

## Requirements
- R1: While reset is applied, and after it is released, the outputs are at rest: ahold=0, eads_n=1, inv=0, boff_n=1, snp_addr_oe=0, snp_done=0, snp_hit=0.
- R2: A go pulse sampled while idle raises ahold after that edge. Two edges later, eads_n goes low and inv goes high for exactly one clock, with ahold still high.
- R3: hitm_n is sampled at the second edge after the edge that drove eads_n low. If it is high (line clean or absent), then after that edge snp_done pulses for one clock with snp_hit=0, ahold drops, and boff_n never goes low.
- R4: If hitm_n is low at the sampling edge and a processor burst is still live, boff_n goes low after that edge for exactly one clock. ahold stays high through that clock and the following one, then drops.
- R5: If hitm_n is low at the sampling edge and no processor burst is live, boff_n stays high and ahold drops after that edge.
- R6: After a modified hit, snp_done pulses for one clock with snp_hit=1. The pulse starts after the first edge at which brdy_n and blast_n are both low.
- R7: A go pulse arriving while a snoop is still in progress is ignored. It neither restarts the sequence nor is remembered for later.
- R8: A processor burst is live from an edge with ads_n low until an edge with brdy_n and blast_n both low, or an edge with boff_n low. A burst that closes at the sampling edge itself does not count as live.
- R9: snp_addr_out carries the address captured with the accepted go. snp_addr_oe is high only during the strobe clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| snp_go | input | 1 | One-cycle snoop request from the agent |
| snp_addr_in | input | ADDR_W | Line address to snoop |
| snp_done | output | 1 | One-cycle snoop completion pulse |
| snp_hit | output | 1 | Result of the last snoop: 1 = modified line was written back |
| ads_n | input | 1 | Processor address strobe, active low |
| brdy_n | input | 1 | Burst ready, active low |
| blast_n | input | 1 | Burst last, active low |
| hitm_n | input | 1 | Hit-modified reply, active low |
| ahold | output | 1 | Address hold, active high |
| eads_n | output | 1 | External address strobe, active low |
| inv | output | 1 | Invalidate request, active high |
| boff_n | output | 1 | Back-off, active low |
| snp_addr_out | output | ADDR_W | Snoop address for the processor's address bus |
| snp_addr_oe | output | 1 | Output enable for snp_addr_out |

## Verification
On every cycle, the assertions check the pin discipline. The strobe lasts one clock and only comes two clocks into address hold. Back-off is a single clock, always inside address hold, and address hold survives one clock past back-off. The done pulse is one clock wide and never overlaps address hold. Only the bench scenarios can show the decision outcomes. These cover whether back-off is issued, depending on burst state and the hit reply, including a burst that closes exactly on the sampling edge. They also cover the captured address, the reported hit flag, and that a go pulse arriving mid-snoop is dropped.

// File: rtl/snb_pkg.sv
package snb_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_HOLD = 3'd1,
    S_TURN = 3'd2,
    S_STRB = 3'd3,
    S_WAITH = 3'd4,
    S_BOFF = 3'd5,
    S_BREL = 3'd6,
    S_WBWT = 3'd7
  } snb_state_e;
endpackage

// File: rtl/snb_burst_trk.sv
// Follows processor bursts: open on address strobe, closed on the last ready
// beat or by back-off.
module snb_burst_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic ads_n,
  input  logic brdy_n,
  input  logic blast_n,
  input  logic boff_n,
  output logic live,
  output logic closing
);
  logic open_q, open_d;

  assign closing = !brdy_n && !blast_n;
  assign live    = open_q && !closing;

  always_comb begin
    open_d = open_q;
    if (!boff_n)     open_d = 1'b0;
    else if (!ads_n) open_d = 1'b1;
    else if (closing) open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end
endmodule

// File: rtl/snb_seq.sv
// Next-state logic of the snoop sequence.
module snb_seq
  import snb_pkg::*;
(
  input  snb_state_e state_q,
  input  logic       go,
  input  logic       hitm_n,
  input  logic       live,
  input  logic       closing,
  output snb_state_e state_d,
  output logic       cap_en,
  output logic       done_d,
  output logic       hit_d
);
  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    done_d  = 1'b0;
    hit_d   = 1'b0;
    case (state_q)
      S_IDLE: if (go) begin
        state_d = S_HOLD;
        cap_en  = 1'b1;
      end
      S_HOLD:  state_d = S_TURN;
      S_TURN:  state_d = S_STRB;
      S_STRB:  state_d = S_WAITH;
      S_WAITH: begin
        if (hitm_n) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else if (live) begin
          state_d = S_BOFF;
        end else begin
          state_d = S_WBWT;
        end
      end
      S_BOFF:  state_d = S_BREL;
      S_BREL:  state_d = S_WBWT;
      S_WBWT: if (closing) begin
        state_d = S_IDLE;
        done_d  = 1'b1;
        hit_d   = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end
endmodule

// File: rtl/snb_pinreg.sv
// Registered pin drivers decoded from the next state.
module snb_pinreg
  import snb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  snb_state_e state_d,
  input  logic       done_d,
  input  logic       hit_d,
  output logic       ahold,
  output logic       eads_n,
  output logic       inv,
  output logic       boff_n,
  output logic       addr_oe,
  output logic       done,
  output logic       hit
);
  logic ahold_d, strb_d, boff_d;

  always_comb begin
    strb_d  = (state_d == S_STRB);
    boff_d  = (state_d == S_BOFF);
    ahold_d = (state_d != S_IDLE) && (state_d != S_WBWT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ahold   <= 1'b0;
      eads_n  <= 1'b1;
      inv     <= 1'b0;
      boff_n  <= 1'b1;
      addr_oe <= 1'b0;
      done    <= 1'b0;
    end else begin
      ahold   <= ahold_d;
      eads_n  <= !strb_d;
      inv     <= strb_d;
      boff_n  <= !boff_d;
      addr_oe <= strb_d;
      done    <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hit <= 1'b0;
    else if (done_d) hit <= hit_d;
  end
endmodule

// File: rtl/snoop_boff_ctl.sv
module snoop_boff_ctl
  import snb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_go,
  input  logic [ADDR_W-1:0] snp_addr_in,
  output logic              snp_done,
  output logic              snp_hit,
  input  logic              ads_n,
  input  logic              brdy_n,
  input  logic              blast_n,
  input  logic              hitm_n,
  output logic              ahold,
  output logic              eads_n,
  output logic              inv,
  output logic              boff_n,
  output logic [ADDR_W-1:0] snp_addr_out,
  output logic              snp_addr_oe
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] rst_pipe;
  logic              rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_MSB-1:0], 1'b1};
  end
  assign rst_s = rst_pipe[SYNC_MSB];

  snb_state_e state_q, state_d;
  logic live, closing, cap_en, done_d, hit_d;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      snp_addr_out <= '0;
    else if (cap_en) snp_addr_out <= snp_addr_in;
  end

  snb_burst_trk u_trk (
    .clk(clk), .rst_n(rst_s), .ads_n(ads_n), .brdy_n(brdy_n),
    .blast_n(blast_n), .boff_n(boff_n), .live(live), .closing(closing)
  );

  snb_seq u_seq (
    .state_q(state_q), .go(snp_go), .hitm_n(hitm_n), .live(live),
    .closing(closing), .state_d(state_d), .cap_en(cap_en),
    .done_d(done_d), .hit_d(hit_d)
  );

  snb_pinreg u_pins (
    .clk(clk), .rst_n(rst_s), .state_d(state_d), .done_d(done_d),
    .hit_d(hit_d), .ahold(ahold), .eads_n(eads_n), .inv(inv),
    .boff_n(boff_n), .addr_oe(snp_addr_oe), .done(snp_done), .hit(snp_hit)
  );
endmodule

// File: rtl/snoop_boff_chk.sv
module snoop_boff_chk (
  input logic clk,
  input logic rst_n,
  input logic ahold,
  input logic eads_n,
  input logic inv,
  input logic boff_n,
  input logic snp_done
);
  p_strobe_one_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !eads_n |=> eads_n);
  p_strobe_in_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eads_n) |-> (ahold && $past(ahold, 2) && inv));
  p_boff_one_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !boff_n |=> boff_n);
  p_boff_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !boff_n |-> (ahold && $past(ahold)));
  p_hold_after_boff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boff_n) |-> ahold);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_done |=> !snp_done);
  p_done_no_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    snp_done |-> !ahold);
endmodule

bind snoop_boff_ctl snoop_boff_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ahold(ahold), .eads_n(eads_n), .inv(inv),
  .boff_n(boff_n), .snp_done(snp_done)
);

// File: tb/snoop_boff_ctl_bench.sv
module snoop_boff_ctl_bench;
  localparam int AW = 32;
  logic clk, rst_n, snp_go, snp_done, snp_hit;
  logic ads_n, brdy_n, blast_n, hitm_n;
  logic ahold, eads_n, inv, boff_n, snp_addr_oe;
  logic [AW-1:0] snp_addr_in, snp_addr_out;
  int checks = 0, misses = 0, cycles = 0;

  // {burst open, closes before go, closes at sample edge, modified, expect back-off}
  localparam logic [4:0] VEC [7] = '{
    5'b00000, 5'b10000, 5'b10011, 5'b00010, 5'b11010, 5'b10110, 5'b10100
  };

  snoop_boff_ctl #(.ADDR_W(AW)) u_snoop_boff_ctl (
    .clk(clk), .rst_n(rst_n), .snp_go(snp_go), .snp_addr_in(snp_addr_in),
    .snp_done(snp_done), .snp_hit(snp_hit), .ads_n(ads_n), .brdy_n(brdy_n),
    .blast_n(blast_n), .hitm_n(hitm_n), .ahold(ahold), .eads_n(eads_n),
    .inv(inv), .boff_n(boff_n), .snp_addr_out(snp_addr_out),
    .snp_addr_oe(snp_addr_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rest_check(input string req);
    check(req, "ahold", ahold, 0);   check(req, "eads_n", eads_n, 1);
    check(req, "inv", inv, 0);       check(req, "boff_n", boff_n, 1);
    check(req, "oe", snp_addr_oe, 0); check(req, "done", snp_done, 0);
  endtask

  task automatic wb_finish();
    brdy_n = 0; blast_n = 0;
    @(negedge clk); brdy_n = 1; blast_n = 1;
    check("R6", "done", snp_done, 1); check("R6", "hit", snp_hit, 1);
    @(negedge clk);
    check("R6", "done after", snp_done, 0);
    check("R7", "no restart", ahold, 0);
  endtask

  task automatic run_vec(input int idx, input logic [4:0] v);
    logic [31:0] a;
    a = 32'h1000_0000 + idx * 64;
    if (v[4]) begin ads_n = 0; @(negedge clk); ads_n = 1; end
    if (v[3]) begin brdy_n = 0; blast_n = 0; @(negedge clk); brdy_n = 1; blast_n = 1; end
    snp_go = 1; snp_addr_in = a;
    @(negedge clk); snp_go = 0; snp_addr_in = '0;
    check("R2", "ahold", ahold, 1); check("R2", "eads_n early", eads_n, 1);
    @(negedge clk);
    check("R2", "ahold", ahold, 1); check("R2", "eads_n early", eads_n, 1);
    @(negedge clk);
    check("R2", "eads_n", eads_n, 0); check("R2", "inv", inv, 1);
    check("R9", "oe", snp_addr_oe, 1); check("R9", "addr", snp_addr_out, a);
    @(negedge clk);
    check("R2", "eads_n end", eads_n, 1); check("R9", "oe end", snp_addr_oe, 0);
    hitm_n = !v[1];
    if (v[2]) begin brdy_n = 0; blast_n = 0; end
    @(negedge clk);
    hitm_n = 1; brdy_n = 1; blast_n = 1;
    if (v[0]) begin
      check("R4", "boff_n", boff_n, 0); check("R4", "ahold", ahold, 1);
      check("R4", "done", snp_done, 0);
      @(negedge clk);
      check("R4", "boff_n release", boff_n, 1); check("R4", "ahold held", ahold, 1);
      @(negedge clk);
      check("R4", "ahold drop", ahold, 0);
      snp_go = 1; snp_addr_in = 32'hDEAD_0000;
      @(negedge clk); snp_go = 0;
      check("R7", "go ignored", ahold, 0);
      wb_finish();
    end else if (v[1]) begin
      check("R8", "boff_n", boff_n, 1); check("R5", "ahold", ahold, 0);
      check("R5", "done", snp_done, 0);
      snp_go = 1;
      @(negedge clk); snp_go = 0;
      check("R7", "go ignored", ahold, 0);
      check("R5", "still no boff", boff_n, 1);
      wb_finish();
    end else begin
      check("R3", "done", snp_done, 1); check("R3", "hit", snp_hit, 0);
      check("R3", "ahold", ahold, 0);   check("R3", "boff_n", boff_n, 1);
      if (v[4] && !v[2]) begin brdy_n = 0; blast_n = 0; end
      @(negedge clk); brdy_n = 1; blast_n = 1;
      check("R3", "done after", snp_done, 0);
    end
    check("R9", "addr kept", snp_addr_out, a);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 20000) begin
        misses++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; snp_go = 0; snp_addr_in = '0;
    ads_n = 1; brdy_n = 1; blast_n = 1; hitm_n = 1;
    repeat (3) @(negedge clk);
    rest_check("R1");
    rst_n = 1;
    repeat (4) @(negedge clk);
    rest_check("R1");
    check("R1", "hit", snp_hit, 0);
    for (int i = 0; i < 7; i++) run_vec(i, VEC[i]);
    // reset in the middle of the strobe clock
    snp_go = 1; snp_addr_in = 32'h0000_0F00;
    @(negedge clk); snp_go = 0;
    @(negedge clk); @(negedge clk);
    check("R2", "eads_n before reset", eads_n, 0);
    rst_n = 0; #1;
    rest_check("R1");
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    rest_check("R1");
    run_vec(9, VEC[0]);
    run_vec(10, VEC[2]);
    $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end
endmodule